// File: doc/BRIEF.md
# Set-Associative Lookup with Aged Reference Counters

This unit holds the tag store and replacement state of an n-way set-associative cache. A lookup presents a set index and a tag. All ways of that set are compared in the same cycle, and the unit reports a hit together with the way that matched. On a miss it names the way that a refill should replace. The refill itself is driven from outside through a fill port that writes a tag into a chosen way.

Replacement approximates least-recently-used with a small saturating reference counter on every line. Any access to a line, whether a lookup hit or a fill, loads its counter with the largest value. A free-running aging timer steps every counter in the cache down by one once per period. A line whose counter has reached zero has not been touched for a while. The victim is an invalid way if the set has one. Otherwise it is the way with the lowest count, which is a zero-count way whenever one exists.

Top module: `assoc_lookup`

## Requirements
- R1: When `req_valid` is high and a valid way of set `req_index` holds `req_tag`, `hit` is 1 and `hit_way` gives that way, in the same cycle.
- R2: When no valid way of the indexed set holds the tag, `hit` is 0. Lines in other sets never produce a hit. `hit` is 0 whenever `req_valid` is 0.
- R3: A lookup hit loads the counter of the matched line with 2^REF_W-1 at the next clock edge. A missing lookup changes no state.
- R4: Every counter in every set is decremented by one, saturating at zero, on every AGE_CYCLES-th clock edge after reset is released. When that edge also carries an access to a line, the access wins and that counter becomes the maximum.
- R5: If the indexed set has an invalid way, `victim_way` is the lowest-numbered invalid way.
- R6: If all ways are valid and some have a zero counter, `victim_way` is the lowest-numbered way with a zero counter.
- R7: If all ways are valid and no counter is zero, `victim_way` is the way with the smallest counter, with ties going to the lowest way number.
- R8: `fill_valid` writes `fill_tag` into way `fill_way` of set `fill_index`, marks the line valid and loads its counter with the maximum at the next edge.
- R9: While `rst_n` is low, every line becomes invalid, every counter becomes zero and the aging timer restarts. Afterwards every lookup misses with victim way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_index | input | IDX_W | Set index of the lookup |
| req_tag | input | TAG_W | Tag compared against the set |
| fill_valid | input | 1 | Write a line into the tag store |
| fill_index | input | IDX_W | Set index of the fill |
| fill_way | input | WAY_W | Way written by the fill |
| fill_tag | input | TAG_W | Tag written by the fill |
| hit | output | 1 | Lookup matched a valid line |
| hit_way | output | WAY_W | Way that matched |
| victim_way | output | WAY_W | Way to replace in the indexed set |

## Verification
Lookups are first run against a partly filled set. There, a hit on each way, a miss whose victim must be the free way, and the same tag in a neighbouring set tell the comparator apart from the invalid-way preference. Once the set is full and has aged to zero, selective hits leave a single zero-count way, and the victim must find it. Counter ladders built across single aging periods (2,2,1,2 and 3,3,2,3) separate a true minimum search from a fixed-order pick, and show ties going to the lowest way. A hit placed on exactly the aging edge shows whether the access beats the decrement, and it also pins the period to the exact cycle.

// File: rtl/assoc_lookup_pkg.sv
package assoc_lookup_pkg;
  localparam int unsigned DFLT_WAYS      = 4;
  localparam int unsigned DFLT_SETS      = 16;
  localparam int unsigned DFLT_TAG_W     = 8;
  localparam int unsigned DFLT_REF_W     = 2;
  localparam int unsigned DFLT_AGE_CYCLES = 64;
endpackage

// File: rtl/assoc_age_timer.sv
module assoc_age_timer #(
  parameter int unsigned AGE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic age_tick
);
  localparam int unsigned CNT_W = (AGE_CYCLES > 2) ? $clog2(AGE_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    age_tick = (cnt_q == CNT_W'(AGE_CYCLES - 1));
    cnt_d    = age_tick ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/assoc_tag_match.sv
module assoc_tag_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 8,
  parameter int unsigned WAY_W = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0]            way_vld,
  input  logic [TAG_W-1:0]           probe_tag,
  input  logic                       probe_en,
  output logic                       match,
  output logic [WAY_W-1:0]           match_way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = way_vld[w] && (way_tag[w] == probe_tag);
  end

  always_comb begin
    match_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) match_way = WAY_W'(w);
    end
    match = probe_en && (|eq);
  end
endmodule

// File: rtl/assoc_victim_pick.sv
module assoc_victim_pick #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned REF_W = 2,
  parameter int unsigned WAY_W = 2
) (
  input  logic [WAYS-1:0]            way_vld,
  input  logic [WAYS-1:0][REF_W-1:0] way_ref,
  output logic [WAY_W-1:0]           victim
);
  logic             free_any;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] min_way;
  logic [REF_W-1:0] min_ref;

  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!way_vld[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    min_way = '0;
    min_ref = way_ref[0];
    for (int w = 1; w < WAYS; w++) begin
      if (way_ref[w] < min_ref) begin
        min_ref = way_ref[w];
        min_way = WAY_W'(w);
      end
    end
    victim = free_any ? free_way : min_way;
  end
endmodule

// File: rtl/assoc_lookup.sv
module assoc_lookup
  import assoc_lookup_pkg::*;
#(
  parameter int unsigned WAYS       = DFLT_WAYS,
  parameter int unsigned SETS       = DFLT_SETS,
  parameter int unsigned TAG_W      = DFLT_TAG_W,
  parameter int unsigned REF_W      = DFLT_REF_W,
  parameter int unsigned AGE_CYCLES = DFLT_AGE_CYCLES,
  localparam int unsigned WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned IDX_W     = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_index,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             fill_valid,
  input  logic [IDX_W-1:0] fill_index,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] victim_way
);
  localparam logic [REF_W-1:0] REF_MAX = '1;

  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q, tag_d;
  logic [SETS-1:0][WAYS-1:0]            vld_q, vld_d;
  logic [SETS-1:0][WAYS-1:0][REF_W-1:0] ref_q, ref_d;
  logic                                 age_tick;
  logic                                 state_en;

  assoc_age_timer #(.AGE_CYCLES(AGE_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .age_tick (age_tick)
  );

  assoc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .way_tag   (tag_q[req_index]),
    .way_vld   (vld_q[req_index]),
    .probe_tag (req_tag),
    .probe_en  (req_valid),
    .match     (hit),
    .match_way (hit_way)
  );

  assoc_victim_pick #(.WAYS(WAYS), .REF_W(REF_W), .WAY_W(WAY_W)) u_pick (
    .way_vld (vld_q[req_index]),
    .way_ref (ref_q[req_index]),
    .victim  (victim_way)
  );

  // Next state: decay first, then accesses override the decayed value.
  always_comb begin
    tag_d = tag_q;
    vld_d = vld_q;
    ref_d = ref_q;
    if (age_tick) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (ref_q[s][w] != '0) ref_d[s][w] = ref_q[s][w] - REF_W'(1);
        end
      end
    end
    if (hit) ref_d[req_index][hit_way] = REF_MAX;
    if (fill_valid) begin
      tag_d[fill_index][fill_way] = fill_tag;
      vld_d[fill_index][fill_way] = 1'b1;
      ref_d[fill_index][fill_way] = REF_MAX;
    end
    state_en = age_tick | hit | fill_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      vld_q <= '0;
      ref_q <= '0;
    end else if (state_en) begin
      tag_q <= tag_d;
      vld_q <= vld_d;
      ref_q <= ref_d;
    end
  end
endmodule

// File: rtl/assoc_lookup_chk.sv
module assoc_lookup_chk #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 8,
  parameter int unsigned REF_W = 2,
  parameter int unsigned WAY_W = 2,
  parameter int unsigned IDX_W = 4
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 req_valid,
  input logic [IDX_W-1:0]                     req_index,
  input logic [TAG_W-1:0]                     req_tag,
  input logic                                 fill_valid,
  input logic [IDX_W-1:0]                     fill_index,
  input logic [WAY_W-1:0]                     fill_way,
  input logic [TAG_W-1:0]                     fill_tag,
  input logic                                 hit,
  input logic [WAY_W-1:0]                     hit_way,
  input logic [WAY_W-1:0]                     victim_way,
  input logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q,
  input logic [SETS-1:0][WAYS-1:0]            vld_q,
  input logic [SETS-1:0][WAYS-1:0][REF_W-1:0] ref_q
);
  localparam logic [REF_W-1:0] REF_MAX = '1;

  // R1
  hit_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (vld_q[req_index][hit_way] && tag_q[req_index][hit_way] == req_tag));

  // R2
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !hit);

  // R3
  touch_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !fill_valid) |=> (ref_q[$past(req_index)][$past(hit_way)] == REF_MAX));

  // R5
  victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[req_index] != '1) |-> !vld_q[req_index][victim_way]);

  // R8
  fill_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (vld_q[$past(fill_index)][$past(fill_way)]
                    && tag_q[$past(fill_index)][$past(fill_way)] == $past(fill_tag)
                    && ref_q[$past(fill_index)][$past(fill_way)] == REF_MAX));
endmodule

bind assoc_lookup assoc_lookup_chk #(
  .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .REF_W(REF_W), .WAY_W(WAY_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
  .req_tag(req_tag), .fill_valid(fill_valid), .fill_index(fill_index),
  .fill_way(fill_way), .fill_tag(fill_tag), .hit(hit), .hit_way(hit_way),
  .victim_way(victim_way), .tag_q(tag_q), .vld_q(vld_q), .ref_q(ref_q)
);

// File: tb/sim_assoc_lookup.sv
module sim_assoc_lookup;
  localparam int AGE = 40;

  logic       clk, rst_n;
  logic       req_valid, fill_valid;
  logic [3:0] req_index, fill_index;
  logic [7:0] req_tag, fill_tag;
  logic [1:0] fill_way;
  logic       hit;
  logic [1:0] hit_way, victim_way;

  int checks = 0;
  int failures = 0;
  int ecnt;
  bit done = 0;

  assoc_lookup #(.WAYS(4), .SETS(16), .TAG_W(8), .REF_W(2), .AGE_CYCLES(AGE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
    .req_tag(req_tag), .fill_valid(fill_valid), .fill_index(fill_index),
    .fill_way(fill_way), .fill_tag(fill_tag), .hit(hit), .hit_way(hit_way),
    .victim_way(victim_way)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;
  end

  typedef struct packed {
    logic       is_fill;
    logic [3:0] idx;
    logic [7:0] tag;
    logic [1:0] way;
    logic       exp_hit;
    logic [1:0] exp_way;
    logic [1:0] exp_vic;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd3, 8'h11, 2'd0, 1'b0, 2'd0, 2'd0, 4'd8},
    '{1'b1, 4'd3, 8'h22, 2'd1, 1'b0, 2'd0, 2'd0, 4'd8},
    '{1'b0, 4'd3, 8'h22, 2'd0, 1'b1, 2'd1, 2'd0, 4'd1},
    '{1'b0, 4'd3, 8'h11, 2'd0, 1'b1, 2'd0, 2'd0, 4'd1},
    '{1'b0, 4'd3, 8'h33, 2'd0, 1'b0, 2'd0, 2'd2, 4'd5},
    '{1'b0, 4'd4, 8'h11, 2'd0, 1'b0, 2'd0, 2'd0, 4'd2},
    '{1'b1, 4'd3, 8'h33, 2'd2, 1'b0, 2'd0, 2'd0, 4'd8},
    '{1'b1, 4'd3, 8'h44, 2'd3, 1'b0, 2'd0, 2'd0, 4'd8},
    '{1'b0, 4'd3, 8'h44, 2'd0, 1'b1, 2'd3, 2'd0, 4'd1},
    '{1'b0, 4'd3, 8'h55, 2'd0, 1'b0, 2'd0, 2'd0, 4'd7}
  };

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // One lookup per clock edge; outputs sampled in the low phase.
  task automatic look(input logic [3:0] idx, input logic [7:0] tag, input bit exp_hit,
                      input int exp_val, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_index = idx; req_tag = tag;
    #1;
    check(rq, "hit", int'(hit), int'(exp_hit));
    if (exp_hit) check(rq, "hit_way", int'(hit_way), exp_val);
    else         check(rq, "victim_way", int'(victim_way), exp_val);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic fill(input logic [3:0] idx, input logic [1:0] way, input logic [7:0] tag);
    @(negedge clk);
    fill_valid = 1'b1; fill_index = idx; fill_way = way; fill_tag = tag;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  // Returns just after the n-th aging edge from now.
  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      while (ecnt % AGE != 0) begin
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; fill_valid = 1'b0;
    req_index = '0; req_tag = '0; fill_index = '0; fill_way = '0; fill_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: empty after reset
    look(4'd3, 8'h00, 1'b0, 0, "R9");

    // Vector table, started just after an aging edge so no decay interferes
    wait_ticks(1);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_fill) fill(VEC[i].idx, VEC[i].way, VEC[i].tag);
      else look(VEC[i].idx, VEC[i].tag, VEC[i].exp_hit,
                VEC[i].exp_hit ? int'(VEC[i].exp_way) : int'(VEC[i].exp_vic),
                $sformatf("R%0d", VEC[i].req));
    end

    // R2: matching tag but no request strobe
    @(negedge clk);
    req_valid = 1'b0; req_index = 4'd3; req_tag = 8'h22;
    #1;
    check("R2", "hit idle", int'(hit), 0);

    // R4: four aging edges bring every counter to zero
    wait_ticks(4);
    look(4'd3, 8'h33, 1'b1, 2, "R1");   // R3: way2 -> 3
    look(4'd3, 8'h55, 1'b0, 0, "R6");   // zeros at 0,1,3
    look(4'd3, 8'h11, 1'b1, 0, "R1");
    look(4'd3, 8'h22, 1'b1, 1, "R1");
    look(4'd3, 8'h55, 1'b0, 3, "R6");   // only way3 at zero
    look(4'd3, 8'h44, 1'b1, 3, "R3");   // all at 3

    // R7: one decay -> all 2; refresh 0,1,3 -> 3,3,2,3
    wait_ticks(1);
    look(4'd3, 8'h11, 1'b1, 0, "R1");
    look(4'd3, 8'h22, 1'b1, 1, "R1");
    look(4'd3, 8'h44, 1'b1, 3, "R1");
    look(4'd3, 8'h55, 1'b0, 2, "R7");
    look(4'd3, 8'h55, 1'b0, 2, "R3");   // miss left state unchanged

    // R7 tie: decay -> 2,2,1,2; refresh way2 -> 2,2,3,2
    wait_ticks(1);
    look(4'd3, 8'h33, 1'b1, 2, "R1");
    look(4'd3, 8'h55, 1'b0, 0, "R7");

    // R8: refill way0 with a new tag -> 3,2,3,2
    fill(4'd3, 2'd0, 8'h66);
    look(4'd3, 8'h11, 1'b0, 1, "R8");
    look(4'd3, 8'h66, 1'b1, 0, "R8");

    // R4: hit landing on the aging edge itself beats the decrement
    wait_ticks(4);
    look(4'd3, 8'h66, 1'b1, 0, "R1");
    look(4'd3, 8'h22, 1'b1, 1, "R1");
    look(4'd3, 8'h33, 1'b1, 2, "R1");
    look(4'd3, 8'h44, 1'b1, 3, "R1");
    @(posedge clk); #1;
    while (ecnt % AGE != AGE - 1) begin
      @(posedge clk); #1;
    end
    look(4'd3, 8'h66, 1'b1, 0, "R4");   // applied on the aging edge
    look(4'd3, 8'h55, 1'b0, 1, "R4");   // 3,2,2,2

    // R9: reset mid-run empties the store
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look(4'd3, 8'h22, 1'b0, 0, "R9");
    look(4'd4, 8'h66, 1'b0, 0, "R9");

    finish_run();
  end
endmodule